// File: doc/BRIEF.md
# E1 Transmit Frame Timing Generator

This block produces the transmit-side timing for a 2.048 Mbit/s E1 stream built from 32 timeslots of 8 bits. It keeps a bit counter, a timeslot counter and a frame counter that spans a 16-frame multiframe. From these counts it decodes a timeslot-rate channel clock, a timeslot-16 flag, an alignment-frame flag and a multiframe marker. It also decodes single-cycle-per-bit strobes that tell downstream capture logic when to take international, national, extra and signalling bits.

Two optional sync inputs, one for frames and one for multiframes, are synchronised inside the clock domain. Their rising edges re-phase the counters. When both inputs are held low, the counters run free. A multiframe sync edge alone also fixes frame alignment. A sync edge that lands on the natural wrap point leaves the phase exactly where free running would have put it.

Top module: `e1_tx_timing`

## Requirements
- R1: A clock edge with rst_n low puts the counters at bit 1, timeslot 0, frame 0. Outputs then read chan_clk=1, ts16_flag=0, align_frame=1, mframe_zero=1 and intl_strobe=1.
- R2: chan_clk is high during bits 1 to 4 of every timeslot and low during bits 5 to 8, so its period is one timeslot.
- R3: ts16_flag is high during all 8 bits of timeslot 16 in every frame and low otherwise.
- R4: mframe_zero is high throughout frame 0 of the 16-frame multiframe and low in frames 1 to 15.
- R5: align_frame is high in even frames (0, 2, ... 14) and low in odd frames.
- R6: With no sync edge, the bit count wraps 8→1 and advances the timeslot, and timeslot 31→0 advances the frame, which wraps 15→0.
- R7: Suppose frame_sync_in is sampled high at rising edge n after being sampled low at edge n-1. Then after edge n+2 the counters show bit 1 of timeslot 0, and the frame number is one more (mod 16) than the frame in progress. An edge that falls on the natural wrap therefore leaves the phase unchanged.
- R8: A rising edge on mframe_sync_in, with the same latency as R7, puts the counters at bit 1, timeslot 0, frame 0. It takes priority over a simultaneous frame sync edge.
- R9: intl_strobe is high during bit 1 of timeslot 0 in every frame. At most one of the four strobes is high at any time.
- R10: With nat_en high, nat_strobe is high during bits 4 to 8 of timeslot 0 in odd frames only. With nat_en low it stays low.
- R11: With cas_en high, extra_strobe is high during bits 5, 7 and 8 of timeslot 16 in frame 0 only. With cas_en low it stays low.
- R12: With cas_en high, sig_strobe is high during all bits of timeslot 16 in frames 1 to 15. With cas_en low it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_sync_in | input | 1 | Frame sync, rising edge re-phases bit and timeslot |
| mframe_sync_in | input | 1 | Multiframe sync, rising edge re-phases to frame 0 |
| cas_en | input | 1 | Enables extra-bit and signalling strobes |
| nat_en | input | 1 | Enables national-bit strobe |
| chan_clk | output | 1 | Timeslot-rate clock, high in first half of each timeslot |
| ts16_flag | output | 1 | High during timeslot 16 |
| align_frame | output | 1 | High during even (alignment) frames |
| mframe_zero | output | 1 | High during frame 0 |
| intl_strobe | output | 1 | International bit strobe |
| nat_strobe | output | 1 | National bit strobe |
| extra_strobe | output | 1 | Extra bit strobe |
| sig_strobe | output | 1 | Signalling bit strobe |

## Verification
The assertions take for granted that the sync inputs are plain levels whose rising edges may arrive at any bit position. They also assume that a sync edge re-phasing the counters is the only thing that breaks their stepwise advance. The stimulus keeps within this by toggling the sync inputs rarely and at random, which gives edges at arbitrary phases. Directed edges are added on the natural wrap point, in mid-frame, and on both inputs in the same cycle. The enables are toggled only between bits, so each bit sees a settled enable value.

// File: rtl/e1_tx_pkg.sv
// Package e1_tx_pkg
// Holds the default E1 frame geometry and the strobe bundle type
// shared by the decode stage and the top level.
package e1_tx_pkg;
    localparam int BITS_PER_TS  = 8;
    localparam int TS_PER_FRAME = 32;
    localparam int FRAMES_PER_MF = 16;
    localparam int SYNC_STAGES  = 2;
    localparam int SIG_SLOT     = 16;

    typedef struct packed {
        logic intl;
        logic nat;
        logic extra;
        logic sig;
    } e1_strobes_t;
endpackage

// File: rtl/e1_sync_edge.sv
// Module e1_sync_edge
// Brings an asynchronous level into the clock domain through STAGES
// flops and emits a one-cycle pulse on its rising edge.
// Assumes STAGES >= 2; reset is synchronous and active low.
module e1_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_pulse
);
    logic [STAGES-1:0] chain;
    logic              prev;

    // Synchroniser chain plus one delay flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], async_in};
            prev  <= chain[STAGES-1];
        end
    end

    // Rising edge of the synchronised level.
    always_comb rise_pulse = chain[STAGES-1] & ~prev;

    // A pulse never lasts two cycles.
    p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rise_pulse |=> !rise_pulse);
endmodule

// File: rtl/e1_wrap_counter.sv
// Module e1_wrap_counter
// Modulo-MOD counter with synchronous clear (highest priority) and an
// advance enable; flags the last count so counters can be chained.
// Assumes MOD >= 2.
module e1_wrap_counter #(
    parameter int MOD = 8,
    localparam int W  = (MOD > 2) ? $clog2(MOD) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         adv,
    output logic [W-1:0] cnt,
    output logic         at_last
);
    // Last-count flag used by the next counter in the chain.
    always_comb at_last = (cnt == W'(MOD - 1));

    // Count register: clear, advance with wrap, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (adv) begin
            cnt <= at_last ? '0 : cnt + W'(1);
        end
    end

    p_clr_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));
    p_adv_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && adv && !at_last) |=> (cnt == $past(cnt) + W'(1)));
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !adv) |=> $stable(cnt));
endmodule

// File: rtl/e1_tx_decode.sv
// Module e1_tx_decode
// Pure combinational decode of the bit, timeslot and frame counts into
// the timing flags and capture strobes. Bit index 0 is bit 1 of a slot.
module e1_tx_decode
    import e1_tx_pkg::*;
#(
    parameter int BIT_W    = 3,
    parameter int TS_W     = 5,
    parameter int FR_W     = 4,
    parameter int BITS     = 8,
    parameter int SIG_TS   = 16
) (
    input  logic [BIT_W-1:0] bit_idx,
    input  logic [TS_W-1:0]  ts_idx,
    input  logic [FR_W-1:0]  fr_idx,
    input  logic             cas_en,
    input  logic             nat_en,
    output logic             chan_clk,
    output logic             ts16_flag,
    output logic             align_frame,
    output logic             mframe_zero,
    output e1_strobes_t      strobes
);
    localparam int HALF      = BITS / 2;
    localparam int NAT_FIRST = 3;   // bit 4
    localparam int XB_A      = 4;   // bit 5
    localparam int XB_B      = 6;   // bit 7
    localparam int XB_C      = 7;   // bit 8

    logic in_ts0;
    logic extra_pos;

    // Slot-level and frame-level flags.
    always_comb begin
        in_ts0      = (ts_idx == '0);
        chan_clk    = (bit_idx < BIT_W'(HALF));
        ts16_flag   = (ts_idx == TS_W'(SIG_TS));
        align_frame = ~fr_idx[0];
        mframe_zero = (fr_idx == '0);
        extra_pos   = (bit_idx == BIT_W'(XB_A)) || (bit_idx == BIT_W'(XB_B)) ||
                      (bit_idx == BIT_W'(XB_C));
    end

    // Capture strobes for the bit fields of timeslots 0 and 16.
    always_comb begin
        strobes.intl  = in_ts0 && (bit_idx == '0);
        strobes.nat   = nat_en && in_ts0 && fr_idx[0] && (bit_idx >= BIT_W'(NAT_FIRST));
        strobes.extra = cas_en && ts16_flag && mframe_zero && extra_pos;
        strobes.sig   = cas_en && ts16_flag && !mframe_zero;
    end
endmodule

// File: rtl/e1_tx_timing.sv
// Module e1_tx_timing
// Top of the E1 transmit timing generator: sync edge detectors, the
// bit/timeslot/frame counter chain and the output decode.
// Assumes the sync inputs may be asynchronous; reset is synchronous.
module e1_tx_timing
    import e1_tx_pkg::*;
#(
    parameter int TS_BITS     = BITS_PER_TS,
    parameter int NUM_TS      = TS_PER_FRAME,
    parameter int NUM_FRAMES  = FRAMES_PER_MF,
    parameter int SYNC_DEPTH  = SYNC_STAGES,
    parameter int SIG_TS      = SIG_SLOT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_sync_in,
    input  logic mframe_sync_in,
    input  logic cas_en,
    input  logic nat_en,
    output logic chan_clk,
    output logic ts16_flag,
    output logic align_frame,
    output logic mframe_zero,
    output logic intl_strobe,
    output logic nat_strobe,
    output logic extra_strobe,
    output logic sig_strobe
);
    localparam int BIT_W = $clog2(TS_BITS);
    localparam int TS_W  = $clog2(NUM_TS);
    localparam int FR_W  = $clog2(NUM_FRAMES);

    logic [1:0]       sync_raw;
    logic [1:0]       sync_edge;     // [0] frame, [1] multiframe
    logic             fs_edge, mf_edge, realign;
    logic [BIT_W-1:0] bit_idx;
    logic [TS_W-1:0]  ts_idx;
    logic [FR_W-1:0]  fr_idx;
    logic             bit_last, ts_last, fr_last;
    e1_strobes_t      strobes;

    always_comb sync_raw = {mframe_sync_in, frame_sync_in};

    // One synchroniser and edge detector per sync input.
    for (genvar g = 0; g < 2; g++) begin : g_sync
        e1_sync_edge #(.STAGES(SYNC_DEPTH)) u_edge (
            .clk        (clk),
            .rst_n      (rst_n),
            .async_in   (sync_raw[g]),
            .rise_pulse (sync_edge[g])
        );
    end

    // Re-phase controls for the counter chain.
    always_comb begin
        fs_edge = sync_edge[0];
        mf_edge = sync_edge[1];
        realign = fs_edge | mf_edge;
    end

    e1_wrap_counter #(.MOD(TS_BITS)) u_bit_cnt (
        .clk (clk), .rst_n (rst_n), .clr (realign), .adv (1'b1),
        .cnt (bit_idx), .at_last (bit_last)
    );

    e1_wrap_counter #(.MOD(NUM_TS)) u_ts_cnt (
        .clk (clk), .rst_n (rst_n), .clr (realign), .adv (bit_last),
        .cnt (ts_idx), .at_last (ts_last)
    );

    e1_wrap_counter #(.MOD(NUM_FRAMES)) u_fr_cnt (
        .clk (clk), .rst_n (rst_n), .clr (mf_edge),
        .adv ((bit_last && ts_last) || fs_edge),
        .cnt (fr_idx), .at_last (fr_last)
    );

    e1_tx_decode #(
        .BIT_W (BIT_W), .TS_W (TS_W), .FR_W (FR_W),
        .BITS (TS_BITS), .SIG_TS (SIG_TS)
    ) u_decode (
        .bit_idx     (bit_idx),
        .ts_idx      (ts_idx),
        .fr_idx      (fr_idx),
        .cas_en      (cas_en),
        .nat_en      (nat_en),
        .chan_clk    (chan_clk),
        .ts16_flag   (ts16_flag),
        .align_frame (align_frame),
        .mframe_zero (mframe_zero),
        .strobes     (strobes)
    );

    // Strobe bundle to ports.
    always_comb begin
        intl_strobe  = strobes.intl;
        nat_strobe   = strobes.nat;
        extra_strobe = strobes.extra;
        sig_strobe   = strobes.sig;
    end

    p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({intl_strobe, nat_strobe, extra_strobe, sig_strobe}));
    p_mf_is_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mframe_zero |-> align_frame);
    p_mf_sync_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mf_edge |=> (mframe_zero && intl_strobe));
    p_fs_sync_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_edge && !mf_edge && fr_last) |=> mframe_zero);
    p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!realign && bit_last && ts_last && fr_last) |=> (mframe_zero && intl_strobe));
endmodule

// File: tb/e1_tx_timing_tb.sv
module e1_tx_timing_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fs = 1'b0, mfs = 1'b0, cas = 1'b0, nat = 1'b0;
    logic chan_clk, ts16, align, mfz, intl, nats, extra, sig;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference position: bit index 0..7, timeslot, frame.
    int mb = 0, mt = 0, mf = 0;
    logic [2:0] fq = '0, mq = '0;

    always #5 clk = ~clk;

    e1_tx_timing u_dut (
        .clk (clk), .rst_n (rst_n),
        .frame_sync_in (fs), .mframe_sync_in (mfs),
        .cas_en (cas), .nat_en (nat),
        .chan_clk (chan_clk), .ts16_flag (ts16), .align_frame (align),
        .mframe_zero (mfz), .intl_strobe (intl), .nat_strobe (nats),
        .extra_strobe (extra), .sig_strobe (sig)
    );

    // Reference counter model built from R1, R6, R7 and R8.
    always @(posedge clk) begin
        if (!rst_n) begin
            mb = 0; mt = 0; mf = 0; fq = '0; mq = '0;
        end else begin
            if (mq[1] && !mq[2]) begin
                mb = 0; mt = 0; mf = 0;
            end else if (fq[1] && !fq[2]) begin
                mb = 0; mt = 0; mf = (mf + 1) % 16;
            end else if (mb == 7) begin
                mb = 0;
                if (mt == 31) begin
                    mt = 0; mf = (mf + 1) % 16;
                end else mt = mt + 1;
            end else mb = mb + 1;
            fq = {fq[1:0], fs};
            mq = {mq[1:0], mfs};
        end
    end

    task automatic chk(input logic got, input logic exp, input string req);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s at b%0d t%0d f%0d: got %b expected %b", req, mb, mt, mf, got, exp);
        end
    endtask

    function automatic logic e_chan(); return mb < 4; endfunction
    function automatic logic e_ts16(); return mt == 16; endfunction
    function automatic logic e_mfz(); return mf == 0; endfunction
    function automatic logic e_align(); return (mf % 2) == 0; endfunction
    function automatic logic e_intl(); return mt == 0 && mb == 0; endfunction
    function automatic logic e_nat(); return nat && mt == 0 && (mf % 2) == 1 && mb >= 3; endfunction
    function automatic logic e_extra();
        return cas && mt == 16 && mf == 0 && (mb == 4 || mb == 6 || mb == 7);
    endfunction
    function automatic logic e_sig(); return cas && mt == 16 && mf != 0; endfunction

    // Compares every output with the reference (R2..R12; R6-R8 via position).
    task automatic check_all();
        chk(chan_clk, e_chan(),  "R2");
        chk(ts16,     e_ts16(),  "R3");
        chk(mfz,      e_mfz(),   "R4/R6/R7/R8");
        chk(align,    e_align(), "R5");
        chk(intl,     e_intl(),  "R9");
        chk(nats,     e_nat(),   "R10");
        chk(extra,    e_extra(), "R11");
        chk(sig,      e_sig(),   "R12");
    endtask

    task automatic step();
        @(negedge clk);
        check_all();
    endtask

    task automatic reset_and_check();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk(chan_clk, 1'b1, "R1"); chk(ts16, 1'b0, "R1");
        chk(align, 1'b1, "R1");    chk(mfz, 1'b1, "R1");
        chk(intl, 1'b1, "R1");
    endtask

    initial begin
        void'($urandom(32'd2181));
        reset_and_check();

        // R6: free run with both sync inputs low, enables toggled occasionally.
        for (int i = 0; i < 9000; i++) begin
            step();
            if ($urandom % 400 == 0) cas = ~cas;
            if ($urandom % 400 == 0) nat = ~nat;
        end

        // R7: frame sync edge landing exactly on the natural wrap.
        cas = 1'b1; nat = 1'b1;
        do step(); while (!(mb == 5 && mt == 31));
        fs = 1'b1;
        for (int i = 0; i < 600; i++) step();
        fs = 1'b0;
        for (int i = 0; i < 50; i++) step();

        // R7: frame sync edge in mid-frame.
        do step(); while (!(mt == 9 && mb == 2));
        fs = 1'b1;
        for (int i = 0; i < 300; i++) step();
        fs = 1'b0;

        // R8: multiframe sync edge in mid-frame.
        do step(); while (!(mt == 20 && mf == 5));
        mfs = 1'b1;
        for (int i = 0; i < 4200; i++) step();
        mfs = 1'b0;

        // R8: both edges together, multiframe wins.
        do step(); while (!(mt == 3 && mf == 7));
        fs = 1'b1; mfs = 1'b1;
        for (int i = 0; i < 300; i++) step();
        fs = 1'b0; mfs = 1'b0;

        // Random sync activity at arbitrary phases.
        for (int i = 0; i < 20000; i++) begin
            step();
            if ($urandom % 300 == 0) fs = ~fs;
            if ($urandom % 900 == 0) mfs = ~mfs;
            if ($urandom % 250 == 0) cas = ~cas;
            if ($urandom % 250 == 0) nat = ~nat;
        end

        // R1: reset in the middle of operation.
        fs = 1'b0; mfs = 1'b0;
        reset_and_check();
        for (int i = 0; i < 600; i++) step();

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Watchdog.
    initial begin
        #(1_500_000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule